// File: doc/BRIEF.md
# Split Memory/IO Chip-Select Decoder

This block produces the chip selects for a 16-bit processor bus whose accesses are marked either by a memory-request strobe or by an IO-request strobe. The two strobes share one address bus and one pair of read and write strobes. The block drives three enables: one for the main RAM, one for a device whose registers sit in a memory window, and one for a port device in IO space. Decoding is partial to keep the logic small. The memory window is recognised from the two top address lines alone, and the port device from the lowest address line alone.

A one-bit shadow register chooses who answers in the upper window. The device answers when the bit is clear, and the RAM behind it answers when the bit is set, so all of the memory space can then be used as RAM. Software changes the bit with an IO write to the port device, and the new value is taken from data bit 0. The block also raises an error flag whenever both request strobes are asserted at the same time.

Top module: `split_cs_decoder`

## Requirements
- R1: After reset the shadow bit is clear, and the upper window (addr[15:14] = 2'b11) selects the device.
- R2: With a memory request, a read or write strobe, addr[15:14] = 2'b11 and the shadow bit clear, win_cs_o is 1 and ram_cs_o is 0.
- R3: With a memory request and a read or write strobe, ram_cs_o is 1 in every other case: addr[15:14] is not 2'b11, or the shadow bit is set.
- R4: port_cs_o is 1 only when there is an IO request, a read or write strobe and addr[0] = 0. The other address bits are ignored, so every even port, including 254, selects the port device.
- R5: With no read or write strobe, or with no request strobe, all three enables are 0.
- R6: An IO write that selects the port device loads data_i[0] into the shadow bit on the next clock edge. No other access changes the bit.
- R7: When mreq_i and ioreq_i are both 1, proto_err_o is 1 and all three enables are 0.
- R8: At most one of ram_cs_o, win_cs_o and port_cs_o is 1 at any time.
- R9: An IO request never drives ram_cs_o or win_cs_o, and a memory request never drives port_cs_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Shared address bus |
| data_i | input | 8 | Write data, bit 0 sets the shadow bit |
| mreq_i | input | 1 | Memory request strobe |
| ioreq_i | input | 1 | IO request strobe |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| ram_cs_o | output | 1 | RAM enable |
| win_cs_o | output | 1 | Memory-window device enable |
| port_cs_o | output | 1 | Port device enable |
| proto_err_o | output | 1 | Both request strobes asserted at once |
| shadow_o | output | 1 | Current shadow bit, 1 means RAM answers in the window |

## Verification
Memory accesses are driven at the edges of the address quadrants, at 0xBFFF, 0xC000 and 0xFFFF, once with the shadow bit clear and once with it set. This separates a correct two-line window decode from one that is off by one line, and it shows whether the shadow bit really hands the window to RAM. Port accesses use 254, other even ports and odd ports such as 255, which proves that only addr[0] is decoded. Further checks look for shadow writes that are wrongly accepted from odd ports, from reads and from memory writes. The last patterns drive each strobe alone, drive both request strobes together, and drive a request with neither read nor write, to confirm that the enables stay off in those cases.

// File: rtl/split_cs_pkg.sv
package split_cs_pkg;
  typedef enum logic [1:0] {
    SPACE_NONE = 2'd0,
    SPACE_MEM  = 2'd1,
    SPACE_IO   = 2'd2,
    SPACE_ERR  = 2'd3
  } space_e;

  typedef struct packed {
    logic ram;
    logic win;
    logic port;
  } cs_t;
endpackage

// File: rtl/space_classify.sv
module space_classify
  import split_cs_pkg::*;
(
  input  logic   mreq_i,
  input  logic   ioreq_i,
  input  logic   rd_i,
  input  logic   wr_i,
  output space_e space_o
);
  logic strobe;
  assign strobe = rd_i | wr_i;

  always_comb begin
    space_o = SPACE_NONE;
    if (mreq_i && ioreq_i)  space_o = SPACE_ERR;
    else if (mreq_i && strobe) space_o = SPACE_MEM;
    else if (ioreq_i && strobe) space_o = SPACE_IO;
  end
endmodule

// File: rtl/cs_select.sv
module cs_select
  import split_cs_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter int unsigned WIN_BITS = 2
) (
  input  space_e           space_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             shadow_i,
  output cs_t              cs_o
);
  localparam int unsigned TOP = AW - WIN_BITS;

  logic in_win;
  assign in_win = &addr_i[AW-1:TOP];

  always_comb begin
    cs_o = '0;
    unique case (space_i)
      SPACE_MEM: begin
        if (in_win && !shadow_i) cs_o.win = 1'b1;
        else                     cs_o.ram = 1'b1;
      end
      SPACE_IO:  cs_o.port = ~addr_i[0];
      default:   cs_o = '0;
    endcase
  end

  always_comb begin
    a_onehot_r8: assert ($onehot0(cs_o));
  end
endmodule

// File: rtl/shadow_reg.sv
module shadow_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (load_i) q_o <= d_i;
  end

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q_o));
endmodule

// File: rtl/split_cs_decoder.sv
module split_cs_decoder
  import split_cs_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter int unsigned DW       = 8,
  parameter int unsigned WIN_BITS = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          mreq_i,
  input  logic          ioreq_i,
  input  logic          rd_i,
  input  logic          wr_i,
  output logic          ram_cs_o,
  output logic          win_cs_o,
  output logic          port_cs_o,
  output logic          proto_err_o,
  output logic          shadow_o
);
  space_e space;
  cs_t    cs;
  logic   shadow_q;

  space_classify i_classify (
    .mreq_i (mreq_i),
    .ioreq_i(ioreq_i),
    .rd_i   (rd_i),
    .wr_i   (wr_i),
    .space_o(space)
  );

  cs_select #(.AW(AW), .WIN_BITS(WIN_BITS)) i_select (
    .space_i (space),
    .addr_i  (addr_i),
    .shadow_i(shadow_q),
    .cs_o    (cs)
  );

  shadow_reg i_shadow (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(cs.port & wr_i),
    .d_i   (data_i[0]),
    .q_o   (shadow_q)
  );

  assign ram_cs_o    = cs.ram;
  assign win_cs_o    = cs.win;
  assign port_cs_o   = cs.port;
  assign proto_err_o = mreq_i & ioreq_i;
  assign shadow_o    = shadow_q;

  p_err_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mreq_i && ioreq_i) |-> !(ram_cs_o || win_cs_o || port_cs_o));
  p_no_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i || wr_i) |-> !(ram_cs_o || win_cs_o || port_cs_o));
  p_io_no_mem_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mreq_i |-> !(ram_cs_o || win_cs_o));
  p_mem_no_port_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ioreq_i |-> !port_cs_o);
  p_port_even_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_cs_o |-> !addr_i[0]);
  p_win_top_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_cs_o |-> (&addr_i[AW-1:AW-WIN_BITS] && !shadow_o));
  p_shadow_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_cs_o && wr_i) |=> (shadow_o == $past(data_i[0])));
endmodule

// File: tb/test_split_cs_decoder.sv
module test_split_cs_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic        mreq = 1'b0, ioreq = 1'b0, rd = 1'b0, wr = 1'b0;
  logic        ram_cs, win_cs, port_cs, perr, shadow;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  split_cs_decoder i_split_cs_decoder (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(data),
    .mreq_i(mreq), .ioreq_i(ioreq), .rd_i(rd), .wr_i(wr),
    .ram_cs_o(ram_cs), .win_cs_o(win_cs), .port_cs_o(port_cs),
    .proto_err_o(perr), .shadow_o(shadow)
  );

  task automatic chk(string req, logic [4:0] act, logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {ram,win,port,err,shadow} act=%b exp=%b", req, act, exp);
    end
  endtask

  // apply after negedge, sample before posedge
  task automatic drive(logic m, logic i, logic r, logic w, logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    mreq = m; ioreq = i; rd = r; wr = w; addr = a; data = d;
    #5;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 16'h0, 8'h0);
  endtask

  function automatic logic [4:0] st();
    return {ram_cs, win_cs, port_cs, perr, shadow};
  endfunction

  task automatic t_reset();
    idle();
    chk("R1", st(), 5'b00000);
    drive(1, 0, 1, 0, 16'hC000, 8'h0);
    chk("R1", st(), 5'b01000);
  endtask

  task automatic t_window(logic sh);
    drive(1, 0, 1, 0, 16'hBFFF, 8'h0);
    chk("R3", st(), {4'b1000, sh});
    drive(1, 0, 0, 1, 16'hC000, 8'h0);
    chk(sh ? "R3" : "R2", st(), sh ? {4'b1000, sh} : {4'b0100, sh});
    drive(1, 0, 1, 0, 16'hFFFF, 8'h0);
    chk(sh ? "R3" : "R2", st(), sh ? {4'b1000, sh} : {4'b0100, sh});
    drive(1, 0, 1, 0, 16'h7FFF, 8'h0);
    chk("R3", st(), {4'b1000, sh});
  endtask

  task automatic t_ports();
    drive(0, 1, 1, 0, 16'd254, 8'h0);
    chk("R4", st(), 5'b00100);
    drive(0, 1, 1, 0, 16'h1234, 8'h0);
    chk("R4", st(), 5'b00100);
    drive(0, 1, 1, 0, 16'd255, 8'h0);
    chk("R4", st(), 5'b00000);
    drive(0, 1, 0, 1, 16'hFFFF, 8'h0);
    chk("R9", st(), 5'b00000);
  endtask

  task automatic t_shadow();
    drive(0, 1, 0, 1, 16'd254, 8'h01);
    idle();
    chk("R6", st(), 5'b00001);
    t_window(1'b1);
    drive(0, 1, 0, 1, 16'd255, 8'h00);   // odd port: ignored
    idle();
    chk("R6", st(), 5'b00001);
    drive(0, 1, 1, 0, 16'd254, 8'h00);   // read: ignored
    idle();
    chk("R6", st(), 5'b00001);
    drive(1, 0, 0, 1, 16'd254, 8'h00);   // mem write: ignored
    idle();
    chk("R6", st(), 5'b00001);
    drive(0, 1, 0, 1, 16'h0010, 8'hFE);  // even alias, bit0 = 0
    idle();
    chk("R6", st(), 5'b00000);
  endtask

  task automatic t_errors();
    drive(1, 1, 1, 0, 16'hC000, 8'h0);
    chk("R7", st(), 5'b00010);
    drive(1, 1, 0, 1, 16'd254, 8'h1);
    idle();
    chk("R7", st(), 5'b00000);
    drive(1, 0, 0, 0, 16'h0000, 8'h0);
    chk("R5", st(), 5'b00000);
    drive(0, 1, 0, 0, 16'd254, 8'h0);
    chk("R5", st(), 5'b00000);
    drive(0, 0, 1, 1, 16'hC000, 8'h0);
    chk("R5", st(), 5'b00000);
  endtask

  task automatic t_exclusive();
    for (int k = 0; k < 64; k++) begin
      drive(k[0], k[1], k[2], k[3], {k[4], k[5], 13'h0, k[4]}, 8'h0);
      n_chk++;
      if ($countones({ram_cs, win_cs, port_cs}) > 1) begin
        n_fail++;
        $display("FAIL R8: enables act=%b exp=at most one set", {ram_cs, win_cs, port_cs});
      end
    end
  endtask

  initial begin
    #50 rst_n = 1'b1;
    t_reset();
    t_window(1'b0);
    t_ports();
    t_shadow();
    t_errors();
    t_exclusive();
    idle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: act=timeout exp=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule